// File: doc/BRIEF.md
# Present-State Resolver for a Four-State Mealy Machine

This block finds out which state a small four-state Mealy machine is in without knowing where that machine started. It drives a one-bit stimulus and a step strobe into the machine, reads back the machine's one-bit response in the same cycle, and reports the resolved state code when a fixed input string has been applied.

There are two modes. In synchronizing mode a five-bit string is applied that steers the machine into one known state from any start state, so the response is not needed. In homing mode a shorter three-bit string is applied, and the three response bits are decoded into the final state. A response word that no correct machine can produce is reported as an error, because it shows that the machine does not follow its specification. A reference model of the machine is supplied as a separate module. It has a load port, so a bench can set any start state, and it can be swapped for another implementation with the same ports.

Top module: `fsm_state_finder`

## Requirements
- R1: After reset `done_o`, `valid_o`, `err_o` and `step_o` are 0 and `state_o` is 00. The state codes are A=00, B=01, C=10 and D=11.
- R2: A `start_i` sampled high while the block is idle starts a run in the mode given by `mode_i`, where 0 is synchronizing and 1 is homing. From the next cycle `step_o` is high for exactly 5 consecutive cycles in synchronizing mode and 3 in homing mode.
- R3: While `step_o` is high, `stim_o` carries one stimulus bit per cycle: 0,1,0,1,0 in synchronizing mode and 0,1,0 in homing mode. `resp_i` is sampled at the same clock edge that ends that bit's cycle. `stim_o` is 0 whenever `step_o` is 0.
- R4: `done_o` is high for exactly one cycle, the cycle right after the last step cycle, and is 0 during a run.
- R5: A synchronizing run ends with `valid_o`=1, `err_o`=0 and `state_o`=01 (B), whatever the responses were.
- R6: A homing run decodes the response word, whose first observed bit is written leftmost. 000 gives C (10), and 101 or 001 give B (01). In each of these cases `valid_o`=1 and `err_o`=0.
- R7: Any other homing response word gives `err_o`=1, `valid_o`=0 and `state_o`=00.
- R8: A `start_i` that arrives while a run is in progress is ignored, together with the `mode_i` that comes with it. The run keeps its length and its stimulus string.
- R9: `valid_o`, `err_o` and `state_o` keep their values from one completed run until `done_o` marks the next one.
- R10: The reference machine steps only when its step input is high, and it loads the given state when its load input is high. Its transitions, written as next state / output for input 0 and then input 1, are: A: C/0, A/0; B: B/1, D/0; C: A/0, B/0; D: B/1, C/0. After it takes a 0 it is never in D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| mode_i | input | 1 | Mode select: 0 synchronizing, 1 homing |
| stim_o | output | 1 | Stimulus bit to the machine |
| step_o | output | 1 | Advance strobe to the machine |
| resp_i | input | 1 | Mealy response bit from the machine |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Resolved state is trustworthy |
| err_o | output | 1 | Response word does not fit the specification |
| state_o | output | 2 | Resolved state code |

## Verification
If the step counter or the latched mode went wrong, the fault would show at once in the pattern of `stim_o` and `step_o`. It would also show in when `done_o` fires, which is either off by one or more cycles or never the expected 3 or 5 cycles after start. A fault in the response history or the decoder shows only in the `done_o` cycle, as a wrong `state_o` or a wrong valid/error pair. It then stays visible on those held outputs until the next run. The bench therefore runs every start state through the reference machine in both modes, and forces every possible response word in both modes.

// File: rtl/fsm_state_finder_pkg.sv
package fsm_state_finder_pkg;

    typedef enum logic [1:0] {ST_A = 2'b00, ST_B = 2'b01, ST_C = 2'b10, ST_D = 2'b11} fsm_state_e;
    typedef enum logic {MODE_SYNC = 1'b0, MODE_HOME = 1'b1} mode_e;

    localparam int CNT_W    = 3;
    localparam int PAT_W    = 1 << CNT_W;
    localparam int SYNC_LEN = 5;
    localparam int HOME_LEN = 3;
    // Bit i is the stimulus applied in step i.
    localparam logic [PAT_W-1:0] SYNC_PAT = 8'b0000_1010;
    localparam logic [PAT_W-1:0] HOME_PAT = 8'b0000_0010;

    typedef struct packed {
        logic       valid;
        logic       err;
        fsm_state_e st;
    } result_t;

    function automatic logic [CNT_W-1:0] seq_len(mode_e m);
        return (m == MODE_SYNC) ? CNT_W'(SYNC_LEN) : CNT_W'(HOME_LEN);
    endfunction

    function automatic logic seq_bit(mode_e m, logic [CNT_W-1:0] i);
        logic [PAT_W-1:0] p;
        p = (m == MODE_SYNC) ? SYNC_PAT : HOME_PAT;
        return p[i];
    endfunction

    function automatic result_t sync_result();
        result_t r;
        r.valid = 1'b1;
        r.err   = 1'b0;
        r.st    = ST_B;
        return r;
    endfunction

    function automatic result_t decode_home(logic [HOME_LEN-1:0] w);
        result_t r;
        r.valid = 1'b1;
        r.err   = 1'b0;
        case (w)
            3'b000:         r.st = ST_C;
            3'b101, 3'b001: r.st = ST_B;
            default: begin
                r.valid = 1'b0;
                r.err   = 1'b1;
                r.st    = ST_A;
            end
        endcase
        return r;
    endfunction

    function automatic fsm_state_e ref_next(fsm_state_e s, logic x);
        case (s)
            ST_A:    return x ? ST_A : ST_C;
            ST_B:    return x ? ST_D : ST_B;
            ST_C:    return x ? ST_B : ST_A;
            default: return x ? ST_C : ST_B;
        endcase
    endfunction

    function automatic logic ref_out(fsm_state_e s, logic x);
        return !x && (s == ST_B || s == ST_D);
    endfunction

endpackage

// File: rtl/mut_fsm.sv
module mut_fsm
    import fsm_state_finder_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [1:0] load_state_i,
    input  logic       step_i,
    input  logic       x_i,
    output logic       y_o,
    output logic [1:0] state_o
);
    fsm_state_e cur_q;

    always_ff @(posedge clk) begin
        if (rst)         cur_q <= ST_A;
        else if (load_i) cur_q <= fsm_state_e'(load_state_i);
        else if (step_i) cur_q <= ref_next(cur_q, x_i);
    end

    assign y_o     = ref_out(cur_q, x_i);
    assign state_o = cur_q;

    // R10: a 0 input never leaves the machine in D
    p_zero_avoids_d_r10: assert property (@(posedge clk) disable iff (rst)
        (step_i && !x_i && !load_i) |=> (cur_q != ST_D));
endmodule

// File: rtl/fsm_state_finder_seq.sv
module fsm_state_finder_seq
    import fsm_state_finder_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  mode_i,
    output logic  step_o,
    output logic  stim_o,
    output logic  last_o,
    output mode_e mode_o
);
    logic             busy_q;
    logic [CNT_W-1:0] idx_q;
    mode_e            mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            mode_q <= MODE_SYNC;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                mode_q <= mode_e'(mode_i);
            end
        end else begin
            idx_q <= idx_q + 1'b1;
            if (last_o) busy_q <= 1'b0;
        end
    end

    assign last_o = busy_q && (idx_q == seq_len(mode_q) - 1'b1);
    assign step_o = busy_q;
    assign stim_o = busy_q && seq_bit(mode_q, idx_q);
    assign mode_o = mode_q;

    // R8: a start during a run leaves the latched mode alone
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start_i) |=> $stable(mode_q));
    // R2: the step index stays inside the chosen string
    p_idx_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (idx_q < seq_len(mode_q)));
endmodule

// File: rtl/fsm_state_finder_cap.sv
module fsm_state_finder_cap #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic         resp_i,
    output logic [W-1:0] word_o
);
    logic [W-2:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst)         hist_q <= '0;
        else if (step_i) hist_q <= word_o[W-2:0];
    end

    // newest response enters on the right, oldest sits leftmost
    assign word_o = {hist_q, resp_i};
endmodule

// File: rtl/fsm_state_finder_res.sv
module fsm_state_finder_res
    import fsm_state_finder_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                last_i,
    input  mode_e               mode_i,
    input  logic [HOME_LEN-1:0] word_i,
    output logic                done_o,
    output result_t             res_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= 1'b0;
            res_o  <= '{valid: 1'b0, err: 1'b0, st: ST_A};
        end else begin
            done_o <= last_i;
            if (last_i)
                res_o <= (mode_i == MODE_SYNC) ? sync_result() : decode_home(word_i);
        end
    end

    // R4: completion is a single-cycle pulse
    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R5: synchronizing always lands on B
    p_sync_is_b_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && mode_i == MODE_SYNC) |-> (res_o.valid && !res_o.err && res_o.st == ST_B));
    // R7: a completed run is either valid or in error, never both
    p_valid_xor_err_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (res_o.valid ^ res_o.err));
    // R9: results hold between completions
    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !last_i |=> $stable(res_o));
endmodule

// File: rtl/fsm_state_finder.sv
module fsm_state_finder
    import fsm_state_finder_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       mode_i,
    output logic       stim_o,
    output logic       step_o,
    input  logic       resp_i,
    output logic       done_o,
    output logic       valid_o,
    output logic       err_o,
    output logic [1:0] state_o
);
    logic                last_w;
    mode_e               mode_w;
    logic [HOME_LEN-1:0] word_w;
    result_t             res_w;

    fsm_state_finder_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .mode_i (mode_i),
        .step_o (step_o),
        .stim_o (stim_o),
        .last_o (last_w),
        .mode_o (mode_w)
    );

    fsm_state_finder_cap #(.W(HOME_LEN)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .step_i(step_o),
        .resp_i(resp_i),
        .word_o(word_w)
    );

    fsm_state_finder_res u_res (
        .clk   (clk),
        .rst   (rst),
        .last_i(last_w),
        .mode_i(mode_w),
        .word_i(word_w),
        .done_o(done_o),
        .res_o (res_w)
    );

    assign valid_o = res_w.valid;
    assign err_o   = res_w.err;
    assign state_o = res_w.st;

    // R3: no stimulus outside the step cycles
    p_stim_gated_r3: assert property (@(posedge clk) disable iff (rst)
        !step_o |-> !stim_o);
    // R4: no completion while stepping
    p_done_not_busy_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !step_o);
endmodule

// File: tb/fsm_state_finder_tb_top.sv
module fsm_state_finder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       mode = 1'b0;
    logic       stim, step, resp, done, valid, err;
    logic [1:0] st;
    logic       ld = 1'b0;
    logic [1:0] ld_st = 2'b00;
    logic       mach_y;
    logic [1:0] mach_st;
    logic       frc_en = 1'b0;
    logic       frc_bit = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    assign resp = frc_en ? frc_bit : mach_y;

    fsm_state_finder dut_i (
        .clk(clk), .rst(rst), .start_i(start), .mode_i(mode),
        .stim_o(stim), .step_o(step), .resp_i(resp),
        .done_o(done), .valid_o(valid), .err_o(err), .state_o(st)
    );

    mut_fsm mach_i (
        .clk(clk), .rst(rst), .load_i(ld), .load_state_i(ld_st),
        .step_i(step), .x_i(stim), .y_o(mach_y), .state_o(mach_st)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // transition table of R10, state codes A=0 B=1 C=2 D=3
    function automatic logic [1:0] m_next(logic [1:0] s, logic x);
        case (s)
            2'd0:    return x ? 2'd0 : 2'd2;
            2'd1:    return x ? 2'd3 : 2'd1;
            2'd2:    return x ? 2'd1 : 2'd0;
            default: return x ? 2'd2 : 2'd1;
        endcase
    endfunction
    function automatic logic m_out(logic [1:0] s, logic x);
        return (s == 2'd1 || s == 2'd3) && !x;
    endfunction

    // homing word decode of R6/R7: {valid, err, state}
    function automatic logic [3:0] exp_home(logic [2:0] w);
        case (w)
            3'b000:         return {2'b10, 2'd2};
            3'b101, 3'b001: return {2'b10, 2'd1};
            default:        return {2'b01, 2'd0};
        endcase
    endfunction

    // one complete run; frc_word bits are applied oldest-first from bit len-1
    task automatic run(input logic m, input logic [1:0] s0, input logic use_frc,
                       input logic [4:0] frc_word, input logic hold_start);
        int          len;
        logic [4:0]  pat;
        logic [1:0]  ms;
        logic [4:0]  w;
        logic [3:0]  e;
        len = m ? 3 : 5;
        pat = m ? 5'b00010 : 5'b01010;
        ms  = s0;
        w   = '0;
        @(negedge clk);
        ld = 1'b1; ld_st = s0;
        @(negedge clk);
        ld = 1'b0; start = 1'b1; mode = m; frc_en = use_frc;
        @(negedge clk);
        start = hold_start;
        mode  = hold_start ? ~m : m;
        for (int i = 0; i < len; i++) begin
            chk(step == 1'b1, "R2 step high in run", step, 1);
            chk(stim == pat[i], "R3 stimulus bit", stim, pat[i]);
            chk(done == 1'b0, "R4 done low in run", done, 0);
            if (use_frc) frc_bit = frc_word[len-1-i];
            w  = {w[3:0], use_frc ? frc_word[len-1-i] : m_out(ms, pat[i])};
            ms = m_next(ms, pat[i]);
            if (i == len - 1) start = 1'b0;
            @(negedge clk);
        end
        chk(step == 1'b0, "R2 step low after run", step, 0);
        chk(done == 1'b1, "R4 done after last step", done, 1);
        if (!m) begin
            chk(valid == 1'b1 && err == 1'b0, "R5 sync valid", {valid, err}, 2);
            chk(st == 2'd1, "R5 sync state B", st, 1);
            if (!use_frc) chk(mach_st == 2'd1, "R10 machine in B after sync", mach_st, 1);
        end else begin
            e = exp_home(w[2:0]);
            chk({valid, err} == e[3:2], (e[3] ? "R6 homing flags" : "R7 homing error flags"),
                {valid, err}, e[3:2]);
            chk(st == e[1:0], (e[3] ? "R6 homing state" : "R7 homing error state"), st, e[1:0]);
            if (!use_frc) chk(mach_st == ms && st == ms, "R6 decoded equals machine", st, ms);
        end
        e = {valid, err, st};
        frc_en = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R4 done one cycle", done, 0);
        chk(step == 1'b0 && stim == 1'b0, "R3 idle stimulus low", {step, stim}, 0);
        repeat (2) @(negedge clk);
        chk({valid, err, st} == e, "R9 results held", {valid, err, st}, e);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk({done, valid, err, step} == 4'b0, "R1 reset flags", {done, valid, err, step}, 0);
        chk(st == 2'b00, "R1 reset state", st, 0);
        // R10 one-step table sweep and the narrowing after a 0
        for (int s = 0; s < 4; s++) begin
            for (int x = 0; x < 2; x++) begin
                @(negedge clk); ld = 1'b1; ld_st = 2'(s);
                @(negedge clk); ld = 1'b0;
                frc_en = 1'b0;
                force mach_i.step_i = 1'b1;
                force mach_i.x_i = 1'(x);
                #0.1;
                chk(mach_y == m_out(2'(s), 1'(x)), "R10 machine output", mach_y, m_out(2'(s), 1'(x)));
                @(negedge clk);
                release mach_i.step_i;
                release mach_i.x_i;
                chk(mach_st == m_next(2'(s), 1'(x)), "R10 machine next state", mach_st, m_next(2'(s), 1'(x)));
                if (x == 0) chk(mach_st != 2'd3, "R10 never D after 0", mach_st, 0);
            end
        end
        // true machine from every start state, both modes
        for (int s = 0; s < 4; s++) begin
            run(1'b0, 2'(s), 1'b0, 5'b0, 1'b0);
            run(1'b1, 2'(s), 1'b0, 5'b0, 1'b0);
        end
        // every forced homing word
        for (int w = 0; w < 8; w++) run(1'b1, 2'd0, 1'b1, 5'(w), 1'b0);
        // every forced synchronizing response string
        for (int w = 0; w < 32; w++) run(1'b0, 2'd2, 1'b1, 5'(w), 1'b0);
        // R8: start held high with the other mode during a run
        run(1'b1, 2'd3, 1'b0, 5'b0, 1'b1);
        run(1'b0, 2'd0, 1'b0, 5'b0, 1'b1);
        run(1'b1, 2'd2, 1'b1, 5'b00110, 1'b1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule